// File: doc/BRIEF.md
# Multi-Session Connection Command Controller

This block sits between a control agent and four per-session connection engines. The agent presents one command at a time on a request/ready interface. The command word packs the session number and the operation. The controller compares each command with the state it keeps for the target session. A command that does not fit that state completes at once with a failure status. A command that fits is passed to the engine of that session as a one-cycle request, and the session's state code is updated.

Engines answer with a done pulse and a fail flag. Several sessions can be busy at the same time. Their answers return as single-cycle completions on one shared output, in whatever order the engines finish. The controller also exposes a vector with one "connection on" bit per session and a 4-bit state code per session, so the agent can see each session's condition without asking.

Top module: `conn_cmd_ctrl`

## Requirements
- R1: The command word `cmdWord` carries the operation in bits [1:0] (00 active open, 01 passive open, 10 active close, 11 reset) and the session number 0 to 3 in bits [3:2].
- R2: A request is taken only on a cycle where `cmdReady` is high. After each accepted request, `cmdReady` stays low for exactly two cycles and is high again on the third.
- R3: Every command ends with one single-cycle `cmdDone` pulse. In that cycle, `cmdStatus[3:0]` repeats the command word and `cmdStatus[4]` is 1 for success and 0 for failure.
- R4: An open (active or passive) is legal only when the session's state is 0000 and no engine request is outstanding for it. A legal open pulses `engReq[session]` for one cycle, with `engOp` equal to the operation, in the cycle after acceptance. The state becomes 0001 for an active open and 0010 for a passive open.
- R5: An active close is legal only on a session in state 0100 (connection ready), and it moves the state to 0110. A close to a session without a connection completes with failure and sends no engine request.
- R6: A successful open sets the session's `connOn` bit and its state to 0100. A successful close or reset clears the bit and sets the state to 0000. A failed open returns the state to 0000. A failed close leaves the state at 0100 with `connOn` still set. A failed reset sets the state to 1000 (unusual condition) and clears `connOn`.
- R7: `rstN` is an active-low synchronous reset. It clears every state code to 0000 and clears `connOn`. `cmdReady` stays low, and requests are ignored, until `initDone` is high.
- R8: A reset command is legal on any session whose state is not 0000. It changes only the addressed session. The state codes and `connOn` bits of all other sessions stay unchanged.
- R9: Any command to a session whose engine request is still outstanding completes with failure.
- R10: Sessions may be commanded back to back, and their completions follow the order in which the engines finish. If several engines finish in the same cycle, the lowest-numbered session completes first and each of the others completes one cycle after the previous one.
- R11: A done pulse from an engine whose session has no outstanding request is ignored and produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| initDone | input | 1 | Initialization finished; enables command acceptance |
| cmdReq | input | 1 | Command request pulse |
| cmdWord | input | 4 | Session number [3:2], operation [1:0] |
| cmdReady | output | 1 | Controller can take a request this cycle |
| cmdDone | output | 1 | Completion pulse |
| cmdStatus | output | 5 | Success flag [4], echoed command word [3:0] |
| engReq | output | 4 | One-cycle request to each session engine |
| engOp | output | 2 | Operation that goes with `engReq` |
| engDone | input | 4 | Engine finished its operation, one bit per session |
| engFail | input | 4 | Engine outcome, read together with `engDone` |
| connOn | output | 4 | Connection-on flag per session |
| sessState | output | 16 | State code per session, session i in bits [4i+3:4i] |

## Verification
The assertions watch the properties that hold on every cycle. After each acceptance, ready stays low for two cycles. Every session whose `connOn` bit is set and that has no pending operation is in the ready state. Every idle session has its bit clear. A rejected command never produces an engine request. Other behaviour can only be shown by the bench's scenarios: the outcome tables for success and failure of each operation, the arrival order of completions when engines finish out of order or in the same cycle, the isolation of untouched sessions during a reset, and the absence of any output after a stray engine done or an early request.

// File: rtl/conn_cmd_pkg.sv
package conn_cmd_pkg;

  localparam int SESS_W = 2;
  localparam int NSESS  = 1 << SESS_W;
  localparam int WORD_W = SESS_W + 2;

  typedef enum logic [1:0] {
    OP_AOPEN  = 2'b00,
    OP_POPEN  = 2'b01,
    OP_ACLOSE = 2'b10,
    OP_RESET  = 2'b11
  } cmdOp_e;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'h0,
    ST_AOPEN  = 4'h1,
    ST_LISTEN = 4'h2,
    ST_POPEN  = 4'h3,
    ST_READY  = 4'h4,
    ST_QCLOSE = 4'h5,
    ST_ACLOSE = 4'h6,
    ST_PCLOSE = 4'h7,
    ST_ODD    = 4'h8
  } sessSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              accept;
    logic [SESS_W-1:0] acceptSess;
    cmdOp_e            acceptOp;
    logic              reject;
    logic [WORD_W-1:0] rejectWord;
    logic              complete;
    logic [SESS_W-1:0] cmplSess;
    logic              cmplOk;
  } strobe_t;

endpackage

// File: rtl/conn_cmd_ctrl_fsm.sv
module conn_cmd_ctrl_fsm
  import conn_cmd_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         initDone,
  input  logic                         cmdReq,
  input  logic [WORD_W-1:0]            cmdWord,
  input  logic [NSESS-1:0][3:0]        sessState,
  input  logic [NSESS-1:0]             sessBusy,
  input  logic [NSESS-1:0]             engDone,
  input  logic [NSESS-1:0]             engFail,
  output logic                         cmdReady,
  output strobe_t                      strb
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0]  holdCnt;
  logic              rejPend;
  logic [WORD_W-1:0] rejWord;
  logic [NSESS-1:0]  donePend;
  logic [NSESS-1:0]  okPend;
  logic [NSESS-1:0]  newDone;
  logic [NSESS-1:0]  grantMask;
  logic [SESS_W-1:0] grantSess;
  logic              grantVld;
  logic              accepted;
  logic              legal;
  logic [SESS_W-1:0] reqSess;
  cmdOp_e            reqOp;
  logic [3:0]        curSt;
  logic              curBusy;

  assign cmdReady = rstN && initDone && (holdCnt == '0);
  assign accepted = cmdReq && cmdReady;
  assign reqSess  = cmdWord[WORD_W-1:2];
  assign reqOp    = cmdOp_e'(cmdWord[1:0]);
  assign curSt    = sessState[reqSess];
  assign curBusy  = sessBusy[reqSess];

  // legality of the incoming command against the session state
  always_comb begin
    unique case (reqOp)
      OP_AOPEN, OP_POPEN: legal = !curBusy && (curSt == ST_IDLE);
      OP_ACLOSE:          legal = !curBusy && (curSt == ST_READY);
      default:            legal = !curBusy && (curSt != ST_IDLE);
    endcase
  end

  // rejection first, then the lowest pending session
  always_comb begin
    grantVld  = 1'b0;
    grantSess = '0;
    grantMask = '0;
    if (!rejPend) begin
      for (int i = NSESS - 1; i >= 0; i--) begin
        if (donePend[i]) begin
          grantVld  = 1'b1;
          grantSess = SESS_W'(i);
        end
      end
      if (grantVld) grantMask[grantSess] = 1'b1;
    end
  end

  assign newDone = engDone & sessBusy & ~donePend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt  <= '0;
      rejPend  <= 1'b0;
      rejWord  <= '0;
      donePend <= '0;
      okPend   <= '0;
    end else begin
      if (accepted)             holdCnt <= CNT_W'(HOLD_CYCLES);
      else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
      rejPend <= accepted && !legal;
      if (accepted)             rejWord <= cmdWord;
      donePend <= (donePend & ~grantMask) | newDone;
      for (int i = 0; i < NSESS; i++) begin
        if (newDone[i]) okPend[i] <= !engFail[i];
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.accept     = accepted && legal;
    strb.acceptSess = reqSess;
    strb.acceptOp   = reqOp;
    strb.reject     = rejPend;
    strb.rejectWord = rejWord;
    strb.complete   = grantVld;
    strb.cmplSess   = grantSess;
    strb.cmplOk     = okPend[grantSess];
  end

  AST_HOLD_TWO: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !cmdReady ##1 !cmdReady);  // R2

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rejPend, grantVld}));  // R3

endmodule

// File: rtl/conn_cmd_dpath.sv
module conn_cmd_dpath
  import conn_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  output logic [NSESS-1:0][3:0] sessState,
  output logic [NSESS-1:0]      sessBusy,
  output logic [NSESS-1:0]      connOn,
  output logic [NSESS-1:0]      engReq,
  output logic [1:0]            engOp,
  output logic                  cmdDone,
  output logic [WORD_W:0]       cmdStatus
);

  logic [NSESS-1:0][1:0] sessOp;

  for (genvar i = 0; i < NSESS; i++) begin : g_sess
    logic hitAcc;
    logic hitCmp;
    assign hitAcc = strb.accept   && (strb.acceptSess == SESS_W'(i));
    assign hitCmp = strb.complete && (strb.cmplSess   == SESS_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sessState[i] <= ST_IDLE;
        sessBusy[i]  <= 1'b0;
        sessOp[i]    <= OP_AOPEN;
        connOn[i]    <= 1'b0;
        engReq[i]    <= 1'b0;
      end else begin
        engReq[i] <= hitAcc;
        if (hitAcc) begin
          sessBusy[i] <= 1'b1;
          sessOp[i]   <= strb.acceptOp;
          unique case (strb.acceptOp)
            OP_AOPEN:  sessState[i] <= ST_AOPEN;
            OP_POPEN:  sessState[i] <= ST_LISTEN;
            OP_ACLOSE: sessState[i] <= ST_ACLOSE;
            default:   sessState[i] <= sessState[i];
          endcase
        end else if (hitCmp) begin
          sessBusy[i] <= 1'b0;
          unique case (cmdOp_e'(sessOp[i]))
            OP_AOPEN, OP_POPEN: begin
              sessState[i] <= strb.cmplOk ? ST_READY : ST_IDLE;
              connOn[i]    <= strb.cmplOk;
            end
            OP_ACLOSE: begin
              sessState[i] <= strb.cmplOk ? ST_IDLE : ST_READY;
              connOn[i]    <= !strb.cmplOk;
            end
            default: begin
              sessState[i] <= strb.cmplOk ? ST_IDLE : ST_ODD;
              connOn[i]    <= 1'b0;
            end
          endcase
        end
      end
    end

    AST_CONN_READY: assert property (@(posedge clk) disable iff (!rstN)
      (connOn[i] && !sessBusy[i]) |-> (sessState[i] == ST_READY));  // R6

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (sessState[i] == ST_IDLE) |-> !connOn[i]);  // R6
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engOp     <= OP_AOPEN;
      cmdDone   <= 1'b0;
      cmdStatus <= '0;
    end else begin
      if (strb.accept) engOp <= strb.acceptOp;
      cmdDone <= strb.reject || strb.complete;
      if (strb.reject)
        cmdStatus <= {1'b0, strb.rejectWord};
      else if (strb.complete)
        cmdStatus <= {strb.cmplOk, strb.cmplSess, sessOp[strb.cmplSess]};
    end
  end

  AST_REJ_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |-> (engReq == '0));  // R5

endmodule

// File: rtl/conn_cmd_ctrl.sv
module conn_cmd_ctrl
  import conn_cmd_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initDone,
  input  logic                 cmdReq,
  input  logic [WORD_W-1:0]    cmdWord,
  output logic                 cmdReady,
  output logic                 cmdDone,
  output logic [WORD_W:0]      cmdStatus,
  output logic [NSESS-1:0]     engReq,
  output logic [1:0]           engOp,
  input  logic [NSESS-1:0]     engDone,
  input  logic [NSESS-1:0]     engFail,
  output logic [NSESS-1:0]     connOn,
  output logic [4*NSESS-1:0]   sessState
);

  strobe_t               strb;
  logic [NSESS-1:0][3:0] stArr;
  logic [NSESS-1:0]      busy;

  conn_cmd_ctrl_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .initDone  (initDone),
    .cmdReq    (cmdReq),
    .cmdWord   (cmdWord),
    .sessState (stArr),
    .sessBusy  (busy),
    .engDone   (engDone),
    .engFail   (engFail),
    .cmdReady  (cmdReady),
    .strb      (strb)
  );

  conn_cmd_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sessState (stArr),
    .sessBusy  (busy),
    .connOn    (connOn),
    .engReq    (engReq),
    .engOp     (engOp),
    .cmdDone   (cmdDone),
    .cmdStatus (cmdStatus)
  );

  assign sessState = stArr;

endmodule

// File: tb/conn_cmd_ctrl_bench.sv
module conn_cmd_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initDone = 1'b0;
  logic        cmdReq = 1'b0;
  logic [3:0]  cmdWord = '0;
  logic        cmdReady;
  logic        cmdDone;
  logic [4:0]  cmdStatus;
  logic [3:0]  engReq;
  logic [1:0]  engOp;
  logic [3:0]  engDone = '0;
  logic [3:0]  engFail = '0;
  logic [3:0]  connOn;
  logic [15:0] sessState;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int logN = 0;
  logic [4:0] logStat [0:63];
  int         logCyc  [0:63];
  logic [3:0] snapReq;
  logic [1:0] snapOp;
  logic       snapR1, snapR2, snapR3;
  bit         finished = 0;

  always #5 clk = ~clk;

  conn_cmd_ctrl u_conn_cmd_ctrl (
    .clk(clk), .rstN(rstN), .initDone(initDone), .cmdReq(cmdReq),
    .cmdWord(cmdWord), .cmdReady(cmdReady), .cmdDone(cmdDone),
    .cmdStatus(cmdStatus), .engReq(engReq), .engOp(engOp),
    .engDone(engDone), .engFail(engFail), .connOn(connOn),
    .sessState(sessState)
  );

  always @(negedge clk) begin
    cycle <= cycle + 1;
    if (cmdDone && logN < 64) begin
      logStat[logN] <= cmdStatus;
      logCyc[logN]  <= cycle;
      logN          <= logN + 1;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] stOf(input int s);
    return sessState[4*s +: 4];
  endfunction

  task automatic sendCmd(input logic [3:0] word);
    for (int n = 0; n < 20 && !cmdReady; n++) tick();
    cmdReq = 1'b1;
    cmdWord = word;
    tick();
    cmdReq = 1'b0;
    snapReq = engReq;
    snapOp = engOp;
    snapR1 = cmdReady;
    tick();
    snapR2 = cmdReady;
    tick();
    snapR3 = cmdReady;
  endtask

  task automatic engFinish(input logic [3:0] mask, input logic [3:0] fail);
    engDone = mask;
    engFail = fail;
    tick();
    engDone = '0;
    engFail = '0;
  endtask

  task automatic waitLog(input int target);
    for (int n = 0; n < 20 && logN < target; n++) tick();
  endtask

  task automatic t_init();
    tick();
    tick();
    rstN = 1'b1;
    tick();
    chk("R7 ready low before init", cmdReady, 0);
    chk("R7 state codes cleared", sessState, 16'h0000);
    chk("R7 connOn cleared", connOn, 4'h0);
    cmdReq = 1'b1;
    cmdWord = 4'h0;
    tick();
    cmdReq = 1'b0;
    chk("R7 early request no engine pulse", engReq, 4'h0);
    for (int n = 0; n < 4; n++) tick();
    chk("R7 early request no completion", logN, 0);
    chk("R7 early request state untouched", sessState, 16'h0000);
    initDone = 1'b1;
    tick();
    chk("R7 ready after init", cmdReady, 1);
  endtask

  task automatic t_active_open();
    sendCmd(4'h0);
    chk("R4 engine pulse session 0", snapReq, 4'h1);
    chk("R1 engine op active open", snapOp, 2'b00);
    chk("R2 ready low cycle 1", snapR1, 0);
    chk("R2 ready low cycle 2", snapR2, 0);
    chk("R2 ready back cycle 3", snapR3, 1);
    chk("R4 state active open processing", stOf(0), 4'h1);
    engFinish(4'h1, 4'h0);
    waitLog(1);
    chk("R3 open success status", logStat[0], 5'h10);
    chk("R6 state ready after open", stOf(0), 4'h4);
    chk("R6 connOn set", connOn, 4'h1);
  endtask

  task automatic t_rejects();
    sendCmd(4'h6);
    chk("R5 close on idle no engine pulse", snapReq, 4'h0);
    waitLog(2);
    chk("R5 close on idle fails", logStat[1], 5'h06);
    chk("R5 idle session unchanged", stOf(1), 4'h0);
    sendCmd(4'h0);
    waitLog(3);
    chk("R4 open on connected fails", logStat[2], 5'h00);
    chk("R4 connected session unchanged", stOf(0), 4'h4);
  endtask

  task automatic t_passive_fail();
    sendCmd(4'h9);
    chk("R1 engine op passive open", snapOp, 2'b01);
    chk("R4 engine pulse session 2", snapReq, 4'h4);
    chk("R4 state listening", stOf(2), 4'h2);
    engFinish(4'h4, 4'h4);
    waitLog(4);
    chk("R3 passive open failure status", logStat[3], 5'h09);
    chk("R6 failed open back to idle", stOf(2), 4'h0);
  endtask

  task automatic t_out_of_order();
    sendCmd(4'h4);
    sendCmd(4'h8);
    sendCmd(4'hC);
    chk("R10 three sessions in flight", {stOf(1), stOf(2), stOf(3)}, 12'h111);
    sendCmd(4'h4);
    waitLog(5);
    chk("R9 command to busy session fails", logStat[4], 5'h04);
    engFinish(4'h8, 4'h0);
    waitLog(6);
    chk("R10 session 3 completes first", logStat[5], 5'h1C);
    engFinish(4'h6, 4'h0);
    waitLog(8);
    chk("R10 same-cycle lower session first", logStat[6], 5'h14);
    chk("R10 higher session second", logStat[7], 5'h18);
    chk("R10 one cycle apart", logCyc[7] - logCyc[6], 1);
    chk("R6 all sessions connected", connOn, 4'hF);
  endtask

  task automatic t_close();
    sendCmd(4'h6);
    chk("R1 engine op active close", snapOp, 2'b10);
    chk("R5 state active close processing", stOf(1), 4'h6);
    engFinish(4'h2, 4'h0);
    waitLog(9);
    chk("R3 close success status", logStat[8], 5'h16);
    chk("R6 closed session idle", stOf(1), 4'h0);
    chk("R6 connOn bit cleared", connOn, 4'hD);
    sendCmd(4'hA);
    engFinish(4'h4, 4'h4);
    waitLog(10);
    chk("R3 close failure status", logStat[9], 5'h0A);
    chk("R6 failed close keeps ready", stOf(2), 4'h4);
    chk("R6 failed close keeps connOn", connOn, 4'hD);
  endtask

  task automatic t_reset_cmd();
    sendCmd(4'hF);
    chk("R1 engine op reset", snapOp, 2'b11);
    engFinish(4'h8, 4'h0);
    waitLog(11);
    chk("R3 reset success status", logStat[10], 5'h1F);
    chk("R8 reset session idle", stOf(3), 4'h0);
    chk("R8 others untouched states", {stOf(0), stOf(1), stOf(2)}, 12'h404);
    chk("R8 others untouched connOn", connOn, 4'h5);
    sendCmd(4'h7);
    waitLog(12);
    chk("R8 reset on idle session fails", logStat[11], 5'h07);
    sendCmd(4'hB);
    engFinish(4'h4, 4'h4);
    waitLog(13);
    chk("R6 reset failure status", logStat[12], 5'h0B);
    chk("R6 failed reset unusual state", stOf(2), 4'h8);
    chk("R6 failed reset clears connOn", connOn, 4'h1);
    sendCmd(4'h8);
    waitLog(14);
    chk("R4 open from unusual state fails", logStat[13], 5'h08);
    sendCmd(4'hB);
    engFinish(4'h4, 4'h0);
    waitLog(15);
    chk("R8 reset recovers unusual state", stOf(2), 4'h0);
  endtask

  task automatic t_stray();
    engFinish(4'h2, 4'h0);
    for (int n = 0; n < 6; n++) tick();
    chk("R11 stray done gives no completion", logN, 15);
    chk("R11 stray done leaves states", sessState, 16'h0004);
  endtask

  initial begin
    t_init();
    t_active_open();
    t_rejects();
    t_passive_fail();
    t_out_of_order();
    t_close();
    t_reset_cmd();
    t_stray();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule